// File: doc/BRIEF.md
# Single-Wire Battery Bus Master

This block is a master for a single-wire, return-to-one serial bus of the kind used to reach a battery fuel gauge. Software talks to it through a small byte-wide register port. It loads a byte, sets a start bit, and then polls or waits on the interrupt line. The master can send a byte, receive a byte from the slave, or send a long low break pulse that resets the slave's bus interface. The line is open-drain. The block only pulls it low through `line_oe`, and it reads the line level back through `line_in`.

Every duration on the wire is counted in system clocks. Each one is a product of a clock divider parameter and a length in timing units: the slot, the short pulse for a 1, the long pulse for a 0, the break, the recovery, the receive sample point and the receive timeout. One self-clearing start bit launches all three operations. A break request bit and a direction bit choose which operation runs. A break ends by raising the timeout flag; it has no completion flag of its own.

Top module: `swb_master`

## Requirements
- R1: After reset, the registers read as follows: transmit data (offset 0x04), receive data (0x08), control (0x0C), flags (0x10) and configuration (0x14) all read 0x00; status (0x18) reads 0x01; `irq` and `line_oe` are 0.
- R2: Offset 0x00 reads {REV_MAJOR, REV_MINOR}, with the major revision in bits 7:4 and the minor revision in bits 3:0. Unmapped offsets read 0.
- R3: A control write with start (bit 4) set, break (bit 2) clear and direction (bit 1) clear sends the transmit byte, least significant bit first. Each bit takes SLOT_U×CLK_DIV clocks, and `line_oe` is high for the first ONE_U×CLK_DIV clocks of the slot for a 1, or ZERO_U×CLK_DIV clocks for a 0. In the clock after the eighth slot ends, flag bit 2 is set and the start bit reads 0.
- R4: A control write with start and break both set holds `line_oe` high for BRK_U×CLK_DIV clocks and then low for REC_U×CLK_DIV clocks. Flag bit 0 (timeout) is then set, and the start and break bits read 0.
- R5: A control write with start set, break clear and direction set keeps `line_oe` low. For each bit, the block finds the slave's falling edge and samples the line SMP_U×CLK_DIV clocks later; a high line is a 1. The bits are assembled least significant bit first. After the eighth bit, the byte is stored at 0x08, flag bit 1 is set and the start bit clears.
- R6: During a receive, if no falling edge arrives within TMO_SLOTS×SLOT_U×CLK_DIV clocks, the block sets flag bit 0 and clears the start bit, and the receive register keeps its old value.
- R7: A read of 0x10 returns the flags and clears them. A flag raised in the same clock as the clearing read survives.
- R8: `irq` is high exactly when control bit 6 is set and at least one flag is set.
- R9: While the start bit is 1, writes to 0x04 and 0x0C are ignored.
- R10: Writing bit 1 of 0x14 aborts any operation and releases the line. Every register returns to its reset value, status bit 0 reads 0 for SRST_CYC clocks, and then it reads 1 again.
- R11: Control bits 0 and 5 and configuration bit 0 are stored and read back, with no other effect. Control bits 3 and 7 read 0.
- R12: `line_oe` is 0 whenever the start bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (clears the flags at 0x10) |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| line_in | input | 1 | Sampled level of the bus line |
| line_oe | output | 1 | Pull the bus line low when 1 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clearing read of the flags that lands in exactly the clock in which the receive timeout fires. The bench counts clocks from the start write, using the timeout length it derives itself, and places the read strobe on that final clock. It then checks that this read returned 0 and that a second read finds the timeout flag. Receives are driven by a behavioural slave that pulls the line for each bit. Transmit and break waveforms are checked against a per-clock prediction.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {OP_TX, OP_RX, OP_BRK} op_e;

  localparam logic [4:0] A_REV = 5'h00;
  localparam logic [4:0] A_TXD = 5'h04;
  localparam logic [4:0] A_RXD = 5'h08;
  localparam logic [4:0] A_CTL = 5'h0C;
  localparam logic [4:0] A_FLG = 5'h10;
  localparam logic [4:0] A_CFG = 5'h14;
  localparam logic [4:0] A_STS = 5'h18;

  localparam int CB_MODE  = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_INIT  = 2;
  localparam int CB_GO    = 4;
  localparam int CB_CLKEN = 5;
  localparam int CB_IEN   = 6;
  localparam logic [7:0] CTL_MASK = 8'h77;

  localparam int FB_TMO = 0;
  localparam int FB_RXC = 1;
  localparam int FB_TXC = 2;

  function automatic int unsigned to_cycles(int unsigned units, int unsigned div);
    return units * div;
  endfunction

  function automatic int unsigned cmax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/swb_sync.sv
module swb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic lvl,
  output logic fall
);
  logic s0, s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b1;
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s0 <= line_in;
      s1 <= s0;
      s2 <= s1;
    end
  end

  assign lvl  = s1;
  assign fall = s2 & ~s1;
endmodule

// File: rtl/swb_engine.sv
module swb_engine import swb_pkg::*; #(
  parameter int unsigned CLK_DIV   = 100,
  parameter int unsigned SLOT_U    = 190,
  parameter int unsigned ONE_U     = 32,
  parameter int unsigned ZERO_U    = 100,
  parameter int unsigned BRK_U     = 190,
  parameter int unsigned REC_U     = 40,
  parameter int unsigned SMP_U     = 65,
  parameter int unsigned TMO_SLOTS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start,
  input  op_e        op,
  input  logic [7:0] tx_byte,
  input  logic       lvl,
  input  logic       fall,
  output logic       line_oe,
  output logic       ev_txc,
  output logic       ev_rxc,
  output logic       ev_tmo,
  output logic [7:0] rx_next
);
  localparam int unsigned SLOT_C = to_cycles(SLOT_U, CLK_DIV);
  localparam int unsigned ONE_C  = to_cycles(ONE_U, CLK_DIV);
  localparam int unsigned ZERO_C = to_cycles(ZERO_U, CLK_DIV);
  localparam int unsigned BRK_C  = to_cycles(BRK_U, CLK_DIV);
  localparam int unsigned REC_C  = to_cycles(REC_U, CLK_DIV);
  localparam int unsigned SMP_C  = to_cycles(SMP_U, CLK_DIV);
  localparam int unsigned TMO_C  = TMO_SLOTS * SLOT_C;
  localparam int unsigned MAX_C  = cmax(cmax(TMO_C, SLOT_C), cmax(BRK_C, REC_C));
  localparam int CW = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_BLO, S_BREC, S_RWAIT, S_RBIT} st_e;

  st_e           st;
  logic [CW-1:0] cnt, lim;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          cnt_end, smp_now, last_bit;

  always_comb begin
    case (st)
      S_BLO:   lim = CW'(BRK_C);
      S_BREC:  lim = CW'(REC_C);
      S_RWAIT: lim = CW'(TMO_C);
      S_RBIT:  lim = CW'(SMP_C);
      default: lim = CW'(SLOT_C);
    endcase
  end

  assign cnt_end  = (cnt == lim - CW'(1));
  assign smp_now  = (st == S_RBIT) && cnt_end;
  assign last_bit = (bidx == 3'd7);
  assign rx_next  = {lvl, sh[7:1]};

  assign ev_txc = (st == S_TX) && cnt_end && last_bit;
  assign ev_rxc = smp_now && last_bit;
  assign ev_tmo = ((st == S_BREC) && cnt_end) || ((st == S_RWAIT) && cnt_end && !fall);

  always_comb begin
    case (st)
      S_TX:    line_oe = (cnt < (sh[0] ? CW'(ONE_C) : CW'(ZERO_C)));
      S_BLO:   line_oe = 1'b1;
      default: line_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
    end else if (abort) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cnt  <= '0;
          bidx <= '0;
          case (op)
            OP_TX:   begin sh <= tx_byte; st <= S_TX; end
            OP_RX:   st <= S_RWAIT;
            default: st <= S_BLO;
          endcase
        end
        S_TX: if (cnt_end) begin
          cnt  <= '0;
          sh   <= {1'b0, sh[7:1]};
          bidx <= bidx + 3'd1;
          if (last_bit) st <= S_IDLE;
        end else cnt <= cnt + CW'(1);
        S_BLO: if (cnt_end) begin
          cnt <= '0;
          st  <= S_BREC;
        end else cnt <= cnt + CW'(1);
        S_BREC: if (cnt_end) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + CW'(1);
        S_RWAIT: if (fall) begin
          cnt <= '0;
          st  <= S_RBIT;
        end else if (cnt_end) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + CW'(1);
        S_RBIT: if (smp_now) begin
          cnt  <= '0;
          sh   <= rx_next;
          bidx <= bidx + 3'd1;
          st   <= last_bit ? S_IDLE : S_RWAIT;
        end else cnt <= cnt + CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swb_master.sv
module swb_master import swb_pkg::*; #(
  parameter int unsigned CLK_DIV   = 100,
  parameter int unsigned SLOT_U    = 190,
  parameter int unsigned ONE_U     = 32,
  parameter int unsigned ZERO_U    = 100,
  parameter int unsigned BRK_U     = 190,
  parameter int unsigned REC_U     = 40,
  parameter int unsigned SMP_U     = 65,
  parameter int unsigned TMO_SLOTS = 4,
  parameter int unsigned SRST_CYC  = 4,
  parameter logic [3:0]  REV_MAJOR = 4'd2,
  parameter logic [3:0]  REV_MINOR = 4'd1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  input  logic       line_in,
  output logic       line_oe,
  output logic       irq
);
  localparam int SW = $clog2(SRST_CYC + 1);

  logic [7:0]    tx_q, rx_q, ctl_q;
  logic [2:0]    flg_q;
  logic          aidle_q;
  logic [SW-1:0] srst_cnt;

  logic srst_busy, srst_req, wr_ctl, start, rd_clear, eng_done;
  logic lvl, fall, ev_txc, ev_rxc, ev_tmo;
  logic [7:0] rx_next;
  op_e op;

  // named events for the checker
  logic go_w, dir_w, init_w, ien_w;
  assign go_w   = ctl_q[CB_GO];
  assign dir_w  = ctl_q[CB_DIR];
  assign init_w = ctl_q[CB_INIT];
  assign ien_w  = ctl_q[CB_IEN];

  assign srst_busy = (srst_cnt != '0);
  assign srst_req  = reg_wr && (reg_addr == A_CFG) && reg_wdata[1] && !srst_busy;
  assign wr_ctl    = reg_wr && (reg_addr == A_CTL) && !go_w && !srst_busy;
  assign start     = wr_ctl && reg_wdata[CB_GO];
  assign op        = reg_wdata[CB_INIT] ? OP_BRK : (reg_wdata[CB_DIR] ? OP_RX : OP_TX);
  assign rd_clear  = reg_rd && (reg_addr == A_FLG);
  assign eng_done  = ev_txc | ev_rxc | ev_tmo;

  swb_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .lvl(lvl), .fall(fall)
  );

  swb_engine #(
    .CLK_DIV(CLK_DIV), .SLOT_U(SLOT_U), .ONE_U(ONE_U), .ZERO_U(ZERO_U),
    .BRK_U(BRK_U), .REC_U(REC_U), .SMP_U(SMP_U), .TMO_SLOTS(TMO_SLOTS)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(srst_req | srst_busy), .start(start),
    .op(op), .tx_byte(tx_q), .lvl(lvl), .fall(fall), .line_oe(line_oe),
    .ev_txc(ev_txc), .ev_rxc(ev_rxc), .ev_tmo(ev_tmo), .rx_next(rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_q     <= '0;
      ctl_q    <= '0;
      flg_q    <= '0;
      aidle_q  <= 1'b0;
      srst_cnt <= '0;
    end else if (srst_req || srst_busy) begin
      tx_q     <= '0;
      rx_q     <= '0;
      ctl_q    <= '0;
      flg_q    <= '0;
      aidle_q  <= 1'b0;
      srst_cnt <= srst_req ? SW'(SRST_CYC) : srst_cnt - SW'(1);
    end else begin
      if (reg_wr && (reg_addr == A_TXD) && !go_w) tx_q <= reg_wdata;
      if (reg_wr && (reg_addr == A_CFG)) aidle_q <= reg_wdata[0];
      if (wr_ctl) ctl_q <= reg_wdata & CTL_MASK;
      else if (eng_done) begin
        ctl_q[CB_GO]   <= 1'b0;
        ctl_q[CB_INIT] <= 1'b0;
      end
      if (ev_rxc) rx_q <= rx_next;
      flg_q <= (rd_clear ? 3'b000 : flg_q) | {ev_txc, ev_rxc, ev_tmo};
    end
  end

  always_comb begin
    case (reg_addr)
      A_REV:   reg_rdata = {REV_MAJOR, REV_MINOR};
      A_TXD:   reg_rdata = tx_q;
      A_RXD:   reg_rdata = rx_q;
      A_CTL:   reg_rdata = ctl_q;
      A_FLG:   reg_rdata = {5'b0, flg_q};
      A_CFG:   reg_rdata = {6'b0, srst_busy, aidle_q};
      A_STS:   reg_rdata = {7'b0, !srst_busy};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = ien_w & (|flg_q);
endmodule

// File: rtl/swb_checker.sv
module swb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       reg_rd,
  input logic       line_oe,
  input logic       irq,
  input logic       go,
  input logic       dir,
  input logic       init,
  input logic       ien,
  input logic [2:0] flg,
  input logic [7:0] tx,
  input logic       eng_done,
  input logic       ev_tmo
);
  logic rd_clr, cfg_rst;
  assign rd_clr  = reg_rd && (reg_addr == 5'h10);
  assign cfg_rst = reg_wr && (reg_addr == 5'h14) && reg_wdata[1];

  AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> !go); // R3
  AST_BRK_CLEARS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> !init); // R4
  AST_RX_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dir && !init) |-> !line_oe); // R5
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !eng_done) |=> (flg == 3'b000)); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien); // R8
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && eng_done && !cfg_rst) |=> irq); // R8
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !cfg_rst) |=> $stable(tx)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !line_oe); // R12
endmodule

bind swb_master swb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rd(reg_rd), .line_oe(line_oe), .irq(irq),
  .go(go_w), .dir(dir_w), .init(init_w), .ien(ien_w), .flg(flg_q),
  .tx(tx_q), .eng_done(eng_done), .ev_tmo(ev_tmo)
);

// File: tb/sim_swb_master.sv
`timescale 1ns/1ps
module sim_swb_master;
  localparam int DIV   = 2;
  localparam int SLOTC = 190 * DIV;
  localparam int ONEC  = 32 * DIV;
  localparam int ZEROC = 100 * DIV;
  localparam int BRKC  = 190 * DIV;
  localparam int RECC  = 40 * DIV;
  localparam int TMOC  = 4 * SLOTC;

  logic clk = 0, rst_n = 0;
  logic [4:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic line_oe, irq;
  logic slv_low = 0;
  wire  line_in = ~(line_oe | slv_low);

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  swb_master #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .line_in(line_in), .line_oe(line_oe), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic expect_rd(input logic [4:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  // per-clock model of the transmit waveform, called right after the start write
  task automatic model_tx(input logic [7:0] b);
    for (int k = 0; k < 8 * SLOTC; k++) begin
      int pos = k % SLOTC;
      int len = b[k / SLOTC] ? ONEC : ZEROC;
      logic e = (pos < len);
      chk(line_oe == e, "R3 tx waveform", line_oe, e);
      @(negedge clk);
    end
  endtask

  task automatic model_brk();
    for (int k = 0; k < BRKC + RECC; k++) begin
      logic e = (k < BRKC);
      chk(line_oe == e, "R4 break waveform", line_oe, e);
      @(negedge clk);
    end
  endtask

  // behavioural slave sending one byte, least significant bit first
  task automatic slave_send(input logic [7:0] b);
    repeat (20) begin
      chk(line_oe == 0, "R5 line released", line_oe, 0);
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      int len = b[i] ? ONEC : ZEROC;
      for (int c = 0; c < SLOTC; c++) begin
        slv_low = (c < len);
        chk(line_oe == 0, "R5 line released", line_oe, 0);
        @(negedge clk);
      end
    end
    slv_low = 0;
  endtask

  task automatic do_rx(input logic [7:0] b);
    wr(5'h0C, 8'h52);
    slave_send(b);
    chk(irq == 1, "R8 irq after rx", irq, 1);
    expect_rd(5'h08, b, "R5 rx byte");
    expect_rd(5'h0C, 8'h42, "R5 go cleared");
    expect_rd(5'h10, 8'h02, "R5 rx flag");
  endtask

  initial begin
    #800000;
    chk(0, "watchdog", 0, 1);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R2
    chk(irq == 0 && line_oe == 0, "R1 outputs", {irq, line_oe}, 0);
    expect_rd(5'h00, 8'h21, "R2 revision");
    expect_rd(5'h1C, 8'h00, "R2 unmapped");
    expect_rd(5'h04, 8'h00, "R1 tx");
    expect_rd(5'h08, 8'h00, "R1 rx");
    expect_rd(5'h0C, 8'h00, "R1 ctl");
    expect_rd(5'h10, 8'h00, "R1 flags");
    expect_rd(5'h14, 8'h00, "R1 cfg");
    expect_rd(5'h18, 8'h01, "R1 status");
    // R11
    wr(5'h0C, 8'h6B);
    expect_rd(5'h0C, 8'h63, "R11 ctl store");
    chk(line_oe == 0, "R11 no effect", line_oe, 0);
    wr(5'h14, 8'h01);
    expect_rd(5'h14, 8'h01, "R11 autoidle");
    chk(line_oe == 0 && irq == 0, "R11 autoidle no effect", {irq, line_oe}, 0);
    wr(5'h14, 8'h00);
    wr(5'h0C, 8'h00);
    // R3 transmit
    wr(5'h04, 8'hA5);
    wr(5'h0C, 8'h70);
    model_tx(8'hA5);
    chk(line_oe == 0, "R12 idle after tx", line_oe, 0);
    chk(irq == 1, "R8 irq on tx done", irq, 1);
    expect_rd(5'h0C, 8'h60, "R3 go cleared");
    expect_rd(5'h10, 8'h04, "R3 tx flag");
    expect_rd(5'h10, 8'h00, "R7 cleared by read");
    chk(irq == 0, "R8 irq off", irq, 0);
    // R4 break, interrupt disabled
    wr(5'h0C, 8'h14);
    model_brk();
    chk(irq == 0, "R8 masked", irq, 0);
    expect_rd(5'h0C, 8'h00, "R4 init/go cleared");
    expect_rd(5'h10, 8'h01, "R4 timeout flag");
    // R9 writes ignored while busy
    wr(5'h0C, 8'h14);
    wr(5'h04, 8'h3C);
    wr(5'h0C, 8'h00);
    expect_rd(5'h0C, 8'h14, "R9 ctl held");
    repeat (BRKC + RECC) @(negedge clk);
    expect_rd(5'h04, 8'hA5, "R9 tx held");
    expect_rd(5'h10, 8'h01, "R4 second break");
    wr(5'h0C, 8'h50);
    model_tx(8'hA5);
    expect_rd(5'h10, 8'h04, "R9 tx resent");
    // R5 receive
    do_rx(8'h96);
    do_rx(8'hF0);
    // R6 timeout with clearing read on the same clock (R7)
    wr(5'h0C, 8'h52);
    repeat (TMOC - 2) @(negedge clk);
    chk(irq == 0, "R6 no early timeout", irq, 0);
    rd(5'h10, v);
    chk(v == 8'h00, "R7 read at event", v, 0);
    chk(irq == 1, "R6 irq on timeout", irq, 1);
    expect_rd(5'h10, 8'h01, "R7 event wins");
    expect_rd(5'h08, 8'hF0, "R6 rx unchanged");
    expect_rd(5'h0C, 8'h42, "R6 go cleared");
    // R10 soft reset during transmit
    wr(5'h04, 8'h11);
    wr(5'h0C, 8'h70);
    repeat (10) @(negedge clk);
    chk(line_oe == 1, "R10 tx running", line_oe, 1);
    wr(5'h14, 8'h03);
    chk(line_oe == 0, "R10 line released", line_oe, 0);
    expect_rd(5'h18, 8'h00, "R10 status busy");
    repeat (6) @(negedge clk);
    expect_rd(5'h18, 8'h01, "R10 status done");
    expect_rd(5'h0C, 8'h00, "R10 ctl default");
    expect_rd(5'h04, 8'h00, "R10 tx default");
    expect_rd(5'h08, 8'h00, "R10 rx default");
    expect_rd(5'h14, 8'h00, "R10 cfg default");
    chk(line_oe == 0 && irq == 0, "R12 quiet after reset", {irq, line_oe}, 0);
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end
endmodule